// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps three tables of 2-bit saturating counters. The first, a per-address table, is indexed by PC bits [IDX_W+1:2]. The second, a history-hashed table, is indexed by those PC bits XOR the global outcome history. The third, a selector table, is also indexed by the PC bits and chooses which of the first two to follow. The fetch side presents a branch PC and the sign of its encoded offset. In the same cycle it gets a taken/not-taken guess and the history value that the guess used.

When the branch resolves, the update side presents the PC, the offset sign, the real outcome and the history value returned at fetch. The block then trains all three tables, shifts the outcome into the global history, and raises a one-cycle mispredict flag if its guess was wrong. After a wrong guess, a busy flag stays high for a parameterised flush penalty, so the pipeline can account for the lost cycles.

The counter reset value is a parameter. A value of 0 (strongly not-taken) makes cold branches strongly not-taken. A value of 1 (weakly not-taken) lets one taken outcome flip the guess. When neither component table has any evidence at a branch, a static rule decides: backward branches are guessed taken and forward branches not-taken.

Top module: `tourney_predictor`

## Requirements
- R1: After reset, a forward branch at any PC is guessed not-taken (predTaken=0) for both reset values 0 and 1.
- R2: A counter value of 2 or 3 means taken. With CNT_RESET=1, one taken update at a PC makes the next forward guess at that PC taken.
- R3: With CNT_RESET=0, one taken update at a cold PC still leaves the next forward guess at that PC not-taken.
- R4: When the per-address counter and the history-hashed counter both hold 1, the guess equals predBackward (1 means a negative offset). After reset with CNT_RESET=1, a backward branch is guessed taken. With CNT_RESET=0 it is guessed not-taken.
- R5: Counters saturate at 0 and 3. Four taken updates followed by one not-taken update at a PC leave its guess taken.
- R6: The selector counter moves only when the two component guesses differ. It moves up when the history-hashed table was right and down otherwise, and a value of 2 or more selects the history-hashed table.
- R7: predHist is 0 after reset. Each update shifts updTaken into bit 0 of predHist, and predHist is unchanged in cycles without an update.
- R8: mispredict is high for exactly the one cycle after an update whose recomputed guess differed from updTaken, and low otherwise.
- R9: flushBusy is high for FLUSH_PENALTY (default 2) cycles following a mispredicted update, and low when no mispredict is pending.
- R10: Replaying a loop of five forward-taken then five forward-not-taken branches, the first pass mispredicts exactly five times for both reset values. Over three passes, the mispredict counts match the behaviour set out in R1 to R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| predPc | input | PC_W | Fetch-side branch address |
| predBackward | input | 1 | 1 when the encoded offset is negative |
| predTaken | output | 1 | Combinational direction guess |
| predHist | output | HIST_W | Global history used by this guess |
| updValid | input | 1 | Resolved branch present this cycle |
| updPc | input | PC_W | Resolved branch address |
| updBackward | input | 1 | Offset sign of the resolved branch |
| updTaken | input | 1 | Real outcome |
| updHist | input | HIST_W | History snapshot returned at fetch |
| mispredict | output | 1 | Guess was wrong, one cycle after update |
| flushBusy | output | 1 | Flush penalty window active |

## Verification
The guess and predHist are combinational, so the bench reads them a short delay after driving predPc, inside the same cycle. mispredict is registered and is due at the first falling edge after the update's rising edge. The scoreboard queues one expected pair per update and pops it exactly at that edge. flushBusy is checked at each of the falling edges following a miss: it must be high at the first FLUSH_PENALTY of them and low at the next one.

// File: rtl/tp_pkg.sv
package tp_pkg;

  typedef logic [1:0] ctr_t;

  typedef struct packed {
    logic trainEn;
    logic histShift;
  } tpStrobe_t;

  // saturating 2-bit step
  function automatic ctr_t ctrStep(ctr_t c, logic up);
    if (up) return (c == 2'd3) ? c : c + 2'd1;
    return (c == 2'd0) ? c : c - 2'd1;
  endfunction

  // both component counters untrained (value 1): static sign rule
  function automatic logic pickDir(ctr_t bim, ctr_t gsh, ctr_t sel, logic backward);
    if (bim == 2'd1 && gsh == 2'd1) return backward;
    return sel[1] ? gsh[1] : bim[1];
  endfunction

endpackage

// File: rtl/tp_datapath.sv
module tp_datapath
  import tp_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int IDX_W = 6,
  parameter int HIST_W = 6,
  parameter int CNT_RESET = 1,
  parameter int SEL_RESET = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  tpStrobe_t         strobe,
  input  logic [PC_W-1:0]   predPc,
  input  logic              predBackward,
  output logic              predTaken,
  output logic [HIST_W-1:0] predHist,
  input  logic [PC_W-1:0]   updPc,
  input  logic              updBackward,
  input  logic              updTaken,
  input  logic [HIST_W-1:0] updHist,
  output logic              updGuess
);

  localparam int DEPTH = 1 << IDX_W;
  localparam ctr_t RST_CTR = ctr_t'(CNT_RESET);
  localparam ctr_t RST_SEL = ctr_t'(SEL_RESET);

  ctr_t bimTab [DEPTH];
  ctr_t gshTab [DEPTH];
  ctr_t selTab [DEPTH];
  logic [HIST_W-1:0] ghr;

  logic [IDX_W-1:0] pIdx, pGIdx, uIdx, uGIdx;
  ctr_t uBim, uGsh, uSel;
  logic unusedPcBits;

  assign unusedPcBits = ^{predPc[PC_W-1:IDX_W+2], predPc[1:0],
                          updPc[PC_W-1:IDX_W+2], updPc[1:0]};

  always_comb begin
    pIdx  = predPc[IDX_W+1:2];
    pGIdx = pIdx ^ IDX_W'(ghr);
    predTaken = pickDir(bimTab[pIdx], gshTab[pGIdx], selTab[pIdx], predBackward);
    predHist  = ghr;
  end

  always_comb begin
    uIdx  = updPc[IDX_W+1:2];
    uGIdx = uIdx ^ IDX_W'(updHist);
    uBim  = bimTab[uIdx];
    uGsh  = gshTab[uGIdx];
    uSel  = selTab[uIdx];
    updGuess = pickDir(uBim, uGsh, uSel, updBackward);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        bimTab[i] <= RST_CTR;
        gshTab[i] <= RST_CTR;
        selTab[i] <= RST_SEL;
      end
    end else if (strobe.trainEn) begin
      bimTab[uIdx]  <= ctrStep(uBim, updTaken);
      gshTab[uGIdx] <= ctrStep(uGsh, updTaken);
      if (uBim[1] != uGsh[1])
        selTab[uIdx] <= ctrStep(uSel, uGsh[1] == updTaken);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) ghr <= '0;
    else if (strobe.histShift) ghr <= {ghr[HIST_W-2:0], updTaken};
  end

endmodule

// File: rtl/tp_control.sv
module tp_control
  import tp_pkg::*;
#(
  parameter int FLUSH_PENALTY = 2
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      updValid,
  input  logic      updGuess,
  input  logic      updTaken,
  output tpStrobe_t strobe,
  output logic      mispredict,
  output logic      flushBusy
);

  localparam int PEN_W = $clog2(FLUSH_PENALTY + 1);

  logic [PEN_W-1:0] penCnt;
  logic missNow;

  always_comb begin
    missNow = updValid && (updGuess != updTaken);
    strobe.trainEn   = updValid;
    strobe.histShift = updValid;
    flushBusy = (penCnt != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mispredict <= 1'b0;
      penCnt     <= '0;
    end else begin
      mispredict <= missNow;
      if (missNow) penCnt <= PEN_W'(FLUSH_PENALTY);
      else if (penCnt != '0) penCnt <= penCnt - 1'b1;
    end
  end

endmodule

// File: rtl/tourney_predictor.sv
module tourney_predictor
  import tp_pkg::*;
#(
  parameter int PC_W = 32,
  parameter int IDX_W = 6,
  parameter int HIST_W = 6,
  parameter int CNT_RESET = 1,
  parameter int SEL_RESET = 1,
  parameter int FLUSH_PENALTY = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PC_W-1:0]   predPc,
  input  logic              predBackward,
  output logic              predTaken,
  output logic [HIST_W-1:0] predHist,
  input  logic              updValid,
  input  logic [PC_W-1:0]   updPc,
  input  logic              updBackward,
  input  logic              updTaken,
  input  logic [HIST_W-1:0] updHist,
  output logic              mispredict,
  output logic              flushBusy
);

  tpStrobe_t strobe;
  logic updGuess;

  tp_datapath #(
    .PC_W(PC_W), .IDX_W(IDX_W), .HIST_W(HIST_W),
    .CNT_RESET(CNT_RESET), .SEL_RESET(SEL_RESET)
  ) dpInst (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .predPc(predPc), .predBackward(predBackward),
    .predTaken(predTaken), .predHist(predHist),
    .updPc(updPc), .updBackward(updBackward), .updTaken(updTaken),
    .updHist(updHist), .updGuess(updGuess)
  );

  tp_control #(.FLUSH_PENALTY(FLUSH_PENALTY)) ctlInst (
    .clk(clk), .rstN(rstN), .updValid(updValid),
    .updGuess(updGuess), .updTaken(updTaken),
    .strobe(strobe), .mispredict(mispredict), .flushBusy(flushBusy)
  );

endmodule

// File: rtl/tourney_predictor_chk.sv
module tourney_predictor_chk #(
  parameter int HIST_W = 6
) (
  input logic              clk,
  input logic              rstN,
  input logic              updValid,
  input logic              updTaken,
  input logic [HIST_W-1:0] predHist,
  input logic              mispredict,
  input logic              flushBusy
);

  // R8
  miss_after_update_chk: assert property (@(posedge clk) disable iff (!rstN)
    mispredict |-> $past(updValid));

  // R9
  miss_opens_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    mispredict |-> flushBusy);

  // R9
  flush_rise_needs_miss_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flushBusy) |-> mispredict);

  // R7
  hist_shift_chk: assert property (@(posedge clk) disable iff (!rstN)
    updValid |=> predHist == {$past(predHist[HIST_W-2:0]), $past(updTaken)});

  // R7
  hist_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !updValid |=> $stable(predHist));

endmodule

bind tourney_predictor tourney_predictor_chk #(.HIST_W(HIST_W)) chkInst (
  .clk(clk), .rstN(rstN), .updValid(updValid), .updTaken(updTaken),
  .predHist(predHist), .mispredict(mispredict), .flushBusy(flushBusy)
);

// File: tb/tb_tourney_predictor.sv
module tb_tourney_predictor;

  localparam int PC_W = 32;
  localparam int HIST_W = 6;
  localparam int PEN = 2;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [PC_W-1:0] predPc = '0;
  logic predBackward = 1'b0;
  logic updValid = 1'b0;
  logic [PC_W-1:0] updPc = '0;
  logic updBackward = 1'b0;
  logic updTaken = 1'b0;
  logic [HIST_W-1:0] updHist = '0;

  logic pt0, pt1, mp0, mp1, fb0, fb1;
  logic [HIST_W-1:0] ph0, ph1;

  always #10 clk = ~clk;

  tourney_predictor #(.CNT_RESET(1), .FLUSH_PENALTY(PEN)) dut (
    .clk(clk), .rstN(rstN), .predPc(predPc), .predBackward(predBackward),
    .predTaken(pt1), .predHist(ph1), .updValid(updValid), .updPc(updPc),
    .updBackward(updBackward), .updTaken(updTaken), .updHist(updHist),
    .mispredict(mp1), .flushBusy(fb1));

  tourney_predictor #(.CNT_RESET(0), .FLUSH_PENALTY(PEN)) dut0 (
    .clk(clk), .rstN(rstN), .predPc(predPc), .predBackward(predBackward),
    .predTaken(pt0), .predHist(ph0), .updValid(updValid), .updPc(updPc),
    .updBackward(updBackward), .updTaken(updTaken), .updHist(updHist),
    .mispredict(mp0), .flushBusy(fb0));

  int checks = 0;
  int failures = 0;
  int misCnt0 = 0;
  int misCnt1 = 0;

  // behavioural model built from the requirements; index 0 = reset 0, 1 = reset 1
  int mB [2][64];
  int mG [2][64];
  int mC [2][64];
  int mH [2];
  int mMiss [2];

  typedef struct packed { bit e0; bit e1; } exp_t;
  exp_t expQ [$];
  bit updSeen = 1'b0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic bit mGuess(int r, int pc, bit back, int hist);
    int i = (pc >> 2) & 63;
    int g = i ^ (hist & 63);
    if (mB[r][i] == 1 && mG[r][g] == 1) return back;
    if (mC[r][i] >= 2) return mG[r][g] >= 2;
    return mB[r][i] >= 2;
  endfunction

  function automatic int sat(int c, bit up);
    if (up) return (c == 3) ? 3 : c + 1;
    return (c == 0) ? 0 : c - 1;
  endfunction

  function automatic bit mTrain(int r, int pc, bit back, bit taken, int hist);
    int i = (pc >> 2) & 63;
    int g = i ^ (hist & 63);
    bit guess = mGuess(r, pc, back, hist);
    bit bp = mB[r][i] >= 2;
    bit gp = mG[r][g] >= 2;
    if (bp != gp) mC[r][i] = sat(mC[r][i], gp == taken);
    mB[r][i] = sat(mB[r][i], taken);
    mG[r][g] = sat(mG[r][g], taken);
    mH[r] = ((mH[r] << 1) | int'(taken)) & 63;
    if (guess != taken) mMiss[r]++;
    return guess != taken;
  endfunction

  task automatic doReset();
    updValid = 1'b0;
    rstN = 1'b0;
    for (int r = 0; r < 2; r++) begin
      for (int i = 0; i < 64; i++) begin
        mB[r][i] = r;
        mG[r][i] = r;
        mC[r][i] = 1;
      end
      mH[r] = 0;
      mMiss[r] = 0;
    end
    expQ.delete();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    misCnt0 = 0;
    misCnt1 = 0;
  endtask

  // driver: guess check in-cycle, expected mispredict queued for the monitor
  task automatic branch(input int pc, input bit back, input bit taken, input string tag);
    exp_t e;
    predPc = PC_W'(pc);
    predBackward = back;
    #1;
    check(pt0 == mGuess(0, pc, back, mH[0]), {tag, " guess reset0"}, pt0, mGuess(0, pc, back, mH[0]));
    check(pt1 == mGuess(1, pc, back, mH[1]), {tag, " guess reset1"}, pt1, mGuess(1, pc, back, mH[1]));
    updHist = ph1;
    updPc = PC_W'(pc);
    updBackward = back;
    updTaken = taken;
    updValid = 1'b1;
    e.e0 = mTrain(0, pc, back, taken, int'(ph0));
    e.e1 = mTrain(1, pc, back, taken, int'(ph1));
    expQ.push_back(e);
    @(negedge clk);
    updValid = 1'b0;
  endtask

  always @(posedge clk) updSeen <= updValid && rstN;

  // monitor: registered mispredict is due at the first falling edge after the update
  always @(negedge clk) begin
    if (updSeen && expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check(mp0 == e.e0, "R8 mispredict reset0", mp0, e.e0);
      check(mp1 == e.e1, "R8 mispredict reset1", mp1, e.e1);
      if (mp0) misCnt0++;
      if (mp1) misCnt1++;
    end else if (rstN) begin
      check(mp0 == 1'b0 && mp1 == 1'b0, "R8 idle mispredict", {mp0, mp1}, 0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    doReset();

    // R1 / R4 / R7: reset state
    predPc = 32'h40; predBackward = 1'b0; #1;
    check(pt0 == 0, "R1 cold forward reset0", pt0, 0);
    check(pt1 == 0, "R1 cold forward reset1", pt1, 0);
    check(ph1 == 0 && ph0 == 0, "R7 history after reset", ph1, 0);
    predBackward = 1'b1; #1;
    check(pt1 == 1, "R4 cold backward reset1", pt1, 1);
    check(pt0 == 0, "R4 cold backward reset0", pt0, 0);
    check(fb0 == 0 && fb1 == 0, "R9 flushBusy after reset", fb1, 0);
    @(negedge clk);

    // R2 / R3: one taken outcome at a cold forward branch
    branch(32'h80, 1'b0, 1'b1, "R2");
    predPc = 32'h80; predBackward = 1'b0; #1;
    check(pt1 == 1, "R2 single taken flips reset1", pt1, 1);
    check(pt0 == 0, "R3 single taken stays NT reset0", pt0, 0);
    @(negedge clk);

    // R9: flush window after the miss at 0xC0
    branch(32'hC0, 1'b0, 1'b1, "R9");
    check(fb1 == 1 && fb0 == 1, "R9 flush cycle 1", fb1, 1);
    @(negedge clk);
    check(fb1 == 1 && fb0 == 1, "R9 flush cycle 2", fb1, 1);
    @(negedge clk);
    check(fb1 == 0 && fb0 == 0, "R9 flush ends", fb1, 0);

    // R7: history shift T,N,T
    doReset();
    branch(32'h10, 1'b0, 1'b1, "R7");
    branch(32'h14, 1'b0, 1'b0, "R7");
    branch(32'h18, 1'b0, 1'b1, "R7");
    @(negedge clk);
    check(ph1 == 6'b000101 && ph0 == 6'b000101, "R7 history T,N,T", ph1, 5);

    // R5: saturation at 3
    doReset();
    for (int k = 0; k < 4; k++) branch(32'h100, 1'b0, 1'b1, "R5");
    branch(32'h100, 1'b0, 1'b0, "R5");
    predPc = 32'h100; predBackward = 1'b0; #1;
    check(pt1 == 1, "R5 saturated guess reset1", pt1, 1);
    check(pt0 == 1, "R5 saturated guess reset0", pt0, 1);
    @(negedge clk);

    // R10 / R6: loop replay, 5 taken then 5 not-taken forward branches
    doReset();
    for (int k = 0; k < 10; k++) branch(32'h200 + 8 * k, 1'b0, k < 5, "R6 loop pass1");
    @(negedge clk);
    check(misCnt0 == 5, "R10 pass1 misses reset0", misCnt0, 5);
    check(misCnt1 == 5, "R10 pass1 misses reset1", misCnt1, 5);
    for (int it = 0; it < 2; it++)
      for (int k = 0; k < 10; k++) branch(32'h200 + 8 * k, 1'b0, k < 5, "R6 loop");
    @(negedge clk);
    check(misCnt0 == mMiss[0], "R10 total misses reset0", misCnt0, mMiss[0]);
    check(misCnt1 == mMiss[1], "R10 total misses reset1", misCnt1, mMiss[1]);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule